// File: doc/BRIEF.md
# SD Host Single-Buffer DMA Engine

This block moves one contiguous buffer between system memory and the data FIFO of an SD host controller. Software sets up a transfer through a small 32-bit register interface. It writes a mode word (direction, beat width, address stepping), a 64-bit start address split over two words and a byte count. It then writes a self-clearing start bit. The engine issues one memory request per beat over a request/acknowledge handshake. Each request carries an address aligned to the beat size. The engine either forwards each returned word into the card FIFO, or takes words out of the card FIFO and writes them to memory.

The engine has two channels, and each can be held in reset. Channel 0 serves memory-to-card transfers and channel 1 serves card-to-memory transfers. Both reset bits are active low. Clearing the bit of the running direction aborts the transfer at once, and setting it again makes the channel usable. When the last beat has been accepted, the engine sets a sticky data-end flag. That flag can raise an interrupt.

Top module: `sd_dma_engine`

## Requirements
- R1: After reset the mode word reads 0, the channel reset word (offset 0x418) reads 0x300 with bit 8 (channel 0) and bit 9 (channel 1) both set, and status reads 0. The mode word (offset 0x410) keeps only bits 17:16, 5:4 and 0, and the control word (offset 0x414) always reads 0, so its start bit clears itself.
- R2: Mode bit 16 = 0 selects memory to card: each beat issues a read request (mem_we = 0), and the returned word is offered on card_wdata with card_wvalid until card_wready. Bit 16 = 1 selects card to memory: a word is popped from the card FIFO and then written with mem_we = 1.
- R3: Mode bits 5:4 select a beat of 1, 2, 4 or 8 bytes (codes 0 to 3), which mem_size carries. A transfer of L bytes issues ceil(L / beat) requests and no more.
- R4: With mode bit 0 = 1 the address grows by the beat size after each beat. With bit 0 = 0 every beat uses the start address.
- R5: The start address is the low word at 0x440 and the high word at 0x444. Stepping carries from the low word into the high word. mem_addr always has its low log2(beat) bits cleared.
- R6: A request holds mem_req, mem_addr and mem_we steady until mem_ack.
- R7: One cycle after the last beat is accepted, status bit 0 (offset 0x420) is set. It stays set until 1 is written to it, and writing 0 leaves it set.
- R8: irq is high exactly while status bit 0 and interrupt-enable bit 0 (offset 0x424) are both set.
- R9: A start written while a transfer runs is ignored, and later writes to mode, address or length do not change the running transfer.
- R10: A start is ignored when the channel for the selected direction is held in reset.
- R11: Clearing the reset bit of the running direction drops all requests on the next cycle, and data-end is not set. After the bit is set again, a new start works.
- R12: A start with a byte count of 0 (length word at 0x41C) issues no request and sets data-end.
- R13: card_rpop is asserted only while card_rvalid is high, and at most one of mem_req, card_wvalid and card_rpop is high at a time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 12 | Register byte offset |
| reg_we | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | 1 = memory write, 0 = memory read |
| mem_addr | output | ADDR_W | Beat-aligned memory address |
| mem_size | output | 2 | Beat width code |
| mem_wdata | output | DATA_W | Memory write data |
| mem_ack | input | 1 | Memory accepted the request |
| mem_rdata | input | DATA_W | Memory read data, valid with mem_ack |
| card_wdata | output | DATA_W | Word toward the card FIFO |
| card_wvalid | output | 1 | card_wdata is valid |
| card_wready | input | 1 | Card FIFO takes the word |
| card_rdata | input | DATA_W | Word from the card FIFO |
| card_rvalid | input | 1 | card_rdata is valid |
| card_rpop | output | 1 | Engine takes card_rdata |
| irq | output | 1 | Data-end interrupt |

## Verification
The bench builds the engine with its defaults: a 64-bit address, a 64-bit data path and a 32-bit byte count. All four beat widths can therefore be reached, including 8-byte beats that carry full random words in both directions. Full 64-bit start addresses are used, one of them with the low word just below wrap, so the carry into the high word and the clearing of unaligned low bits are observed at mem_addr. Byte counts that are not a multiple of the beat, zero counts, starts during a transfer, starts into a channel held in reset, and aborts in the middle of a transfer are mixed with random transfers that have random handshake delays.

// File: rtl/sd_dma_pkg.sv
package sd_dma_pkg;

    localparam int REG_AW = 12;

    localparam logic [REG_AW-1:0] OFS_MODE  = 12'h410;
    localparam logic [REG_AW-1:0] OFS_CTRL  = 12'h414;
    localparam logic [REG_AW-1:0] OFS_CHRST = 12'h418;
    localparam logic [REG_AW-1:0] OFS_LEN   = 12'h41C;
    localparam logic [REG_AW-1:0] OFS_STAT  = 12'h420;
    localparam logic [REG_AW-1:0] OFS_IEN   = 12'h424;
    localparam logic [REG_AW-1:0] OFS_ALO   = 12'h440;
    localparam logic [REG_AW-1:0] OFS_AHI   = 12'h444;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_MRD,
        ST_CPUSH,
        ST_CPOP,
        ST_MWR,
        ST_DONE
    } xfer_state_e;

    typedef struct packed {
        logic [1:0] dir;
        logic [1:0] width;
        logic       incr;
    } mode_t;

endpackage

// File: rtl/sd_dma_regs.sv
module sd_dma_regs
    import sd_dma_pkg::*;
#(
    parameter int ADDR_W = 64,
    parameter int LEN_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic              reg_we,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output mode_t             mode_o,
    output logic [ADDR_W-1:0] base_o,
    output logic [LEN_W-1:0]  len_o,
    output logic [1:0]        rel_o,
    output logic              start_o,
    input  logic              done_i,
    output logic              irq_o
);
    localparam int HI_W = ADDR_W - 32;

    typedef struct packed {
        mode_t            mode;
        logic [31:0]      alo;
        logic [HI_W-1:0]  ahi;
        logic [LEN_W-1:0] len;
        logic [1:0]       rel;
        logic             dend;
        logic             ien;
    } regs_t;

    regs_t q, d;

    always_comb begin
        d = q;
        if (reg_we) begin
            case (reg_addr)
                OFS_MODE: begin
                    d.mode.dir   = reg_wdata[17:16];
                    d.mode.width = reg_wdata[5:4];
                    d.mode.incr  = reg_wdata[0];
                end
                OFS_ALO:   d.alo = reg_wdata;
                OFS_AHI:   d.ahi = reg_wdata[HI_W-1:0];
                OFS_LEN:   d.len = reg_wdata[LEN_W-1:0];
                OFS_CHRST: d.rel = reg_wdata[9:8];
                OFS_STAT:  if (reg_wdata[0]) d.dend = 1'b0;
                OFS_IEN:   d.ien = reg_wdata[0];
                default: ;
            endcase
        end
        if (done_i) d.dend = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q     <= '0;
            q.rel <= 2'b11;
        end else begin
            q <= d;
        end
    end

    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            OFS_MODE:  reg_rdata = {14'd0, q.mode.dir, 10'd0, q.mode.width, 3'd0, q.mode.incr};
            OFS_ALO:   reg_rdata = q.alo;
            OFS_AHI:   reg_rdata = 32'(q.ahi);
            OFS_LEN:   reg_rdata = 32'(q.len);
            OFS_CHRST: reg_rdata = {22'd0, q.rel, 8'd0};
            OFS_STAT:  reg_rdata = {31'd0, q.dend};
            OFS_IEN:   reg_rdata = {31'd0, q.ien};
            default:   reg_rdata = '0;
        endcase
    end

    assign mode_o  = q.mode;
    assign base_o  = {q.ahi, q.alo};
    assign len_o   = q.len;
    assign rel_o   = q.rel;
    assign start_o = reg_we && (reg_addr == OFS_CTRL) && reg_wdata[0];
    assign irq_o   = q.dend && q.ien;

    // R7
    dend_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q.dend) |-> $past(done_i));

endmodule

// File: rtl/sd_dma_addr_gen.sv
module sd_dma_addr_gen #(
    parameter int ADDR_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic [ADDR_W-1:0] base_i,
    input  logic [1:0]        width_i,
    input  logic              incr_i,
    input  logic              step_i,
    output logic [ADDR_W-1:0] addr_o,
    output logic [1:0]        size_o
);
    typedef struct packed {
        logic [ADDR_W-1:0] cur;
        logic [1:0]        width;
        logic              incr;
    } ag_t;

    ag_t q, d;
    logic [ADDR_W-1:0] beat_bytes;
    logic [ADDR_W-1:0] low_mask;

    always_comb begin
        beat_bytes = ADDR_W'(1) << q.width;
        low_mask   = beat_bytes - ADDR_W'(1);
        d = q;
        if (load_i) begin
            d.cur   = base_i;
            d.width = width_i;
            d.incr  = incr_i;
        end else if (step_i && q.incr) begin
            d.cur = q.cur + beat_bytes;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign addr_o = q.cur & ~low_mask;
    assign size_o = q.width;

endmodule

// File: rtl/sd_dma_xfer.sv
module sd_dma_xfer
    import sd_dma_pkg::*;
#(
    parameter int DATA_W = 64,
    parameter int LEN_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  mode_t             mode_i,
    input  logic [LEN_W-1:0]  len_i,
    input  logic [1:0]        rel_i,
    output logic              load_o,
    output logic              step_o,
    output logic              busy_o,
    output logic              dir_o,
    output logic              done_o,
    output logic              mem_req,
    output logic              mem_we,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic              mem_ack,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic [DATA_W-1:0] card_wdata,
    output logic              card_wvalid,
    input  logic              card_wready,
    input  logic [DATA_W-1:0] card_rdata,
    input  logic              card_rvalid,
    output logic              card_rpop
);
    typedef struct packed {
        xfer_state_e       st;
        logic              to_mem;
        logic [1:0]        width;
        logic [LEN_W-1:0]  rem;
        logic [DATA_W-1:0] hold;
    } xf_t;

    xf_t q, d;
    logic [LEN_W-1:0] beat_bytes;
    logic             last_beat;
    logic             chan_ok;
    logic             sel_ok;

    always_comb begin
        beat_bytes = LEN_W'(1) << q.width;
        last_beat  = (q.rem <= beat_bytes);
        chan_ok    = q.to_mem ? rel_i[1] : rel_i[0];
        sel_ok     = mode_i.dir[0] ? rel_i[1] : rel_i[0];
        load_o     = (q.st == ST_IDLE) && start_i && sel_ok;
        step_o     = ((q.st == ST_CPUSH) && card_wready) || ((q.st == ST_MWR) && mem_ack);
        d = q;
        case (q.st)
            ST_IDLE: if (load_o) begin
                d.to_mem = mode_i.dir[0];
                d.width  = mode_i.width;
                d.rem    = len_i;
                if (len_i == '0)        d.st = ST_DONE;
                else if (mode_i.dir[0]) d.st = ST_CPOP;
                else                    d.st = ST_MRD;
            end
            ST_MRD: if (mem_ack) begin
                d.hold = mem_rdata;
                d.st   = ST_CPUSH;
            end
            ST_CPUSH: if (card_wready) begin
                d.rem = q.rem - beat_bytes;
                d.st  = last_beat ? ST_DONE : ST_MRD;
            end
            ST_CPOP: if (card_rvalid) begin
                d.hold = card_rdata;
                d.st   = ST_MWR;
            end
            ST_MWR: if (mem_ack) begin
                d.rem = q.rem - beat_bytes;
                d.st  = last_beat ? ST_DONE : ST_CPOP;
            end
            ST_DONE: d.st = ST_IDLE;
            default: d.st = ST_IDLE;
        endcase
        if (q.st != ST_IDLE && q.st != ST_DONE && !chan_ok) d.st = ST_IDLE;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q    <= '0;
            q.st <= ST_IDLE;
        end else begin
            q <= d;
        end
    end

    assign busy_o      = (q.st != ST_IDLE);
    assign dir_o       = q.to_mem;
    assign done_o      = (q.st == ST_DONE);
    assign mem_req     = (q.st == ST_MRD) || (q.st == ST_MWR);
    assign mem_we      = (q.st == ST_MWR);
    assign mem_wdata   = q.hold;
    assign card_wdata  = q.hold;
    assign card_wvalid = (q.st == ST_CPUSH);
    assign card_rpop   = (q.st == ST_CPOP) && card_rvalid;

    // R9
    busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && start_i && !step_o) |=> $stable(q.rem));

endmodule

// File: rtl/sd_dma_engine.sv
module sd_dma_engine
    import sd_dma_pkg::*;
#(
    parameter int ADDR_W = 64,
    parameter int DATA_W = 64,
    parameter int LEN_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [11:0]       reg_addr,
    input  logic              reg_we,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [1:0]        mem_size,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic              mem_ack,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic [DATA_W-1:0] card_wdata,
    output logic              card_wvalid,
    input  logic              card_wready,
    input  logic [DATA_W-1:0] card_rdata,
    input  logic              card_rvalid,
    output logic              card_rpop,
    output logic              irq
);
    mode_t             mode;
    logic [ADDR_W-1:0] base;
    logic [LEN_W-1:0]  len;
    logic [1:0]        rel;
    logic              start, done, load, step, busy, dir;

    sd_dma_regs #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .reg_addr(reg_addr), .reg_we(reg_we), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .mode_o(mode), .base_o(base), .len_o(len), .rel_o(rel),
        .start_o(start), .done_i(done), .irq_o(irq)
    );

    sd_dma_addr_gen #(.ADDR_W(ADDR_W)) u_addr (
        .clk(clk), .rst_n(rst_n),
        .load_i(load), .base_i(base), .width_i(mode.width), .incr_i(mode.incr),
        .step_i(step), .addr_o(mem_addr), .size_o(mem_size)
    );

    sd_dma_xfer #(.DATA_W(DATA_W), .LEN_W(LEN_W)) u_xfer (
        .clk(clk), .rst_n(rst_n),
        .start_i(start), .mode_i(mode), .len_i(len), .rel_i(rel),
        .load_o(load), .step_o(step), .busy_o(busy), .dir_o(dir), .done_o(done),
        .mem_req(mem_req), .mem_we(mem_we), .mem_wdata(mem_wdata),
        .mem_ack(mem_ack), .mem_rdata(mem_rdata),
        .card_wdata(card_wdata), .card_wvalid(card_wvalid), .card_wready(card_wready),
        .card_rdata(card_rdata), .card_rvalid(card_rvalid), .card_rpop(card_rpop)
    );

    // R6
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack && rel[dir]) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

    // R10
    held_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && !rel[mode.dir[0]]) |=> !busy);

    // R11
    abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !rel[dir]) |=> (!mem_req && !card_wvalid && !card_rpop));

    // R13
    one_side_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({mem_req, card_wvalid, card_rpop}));

endmodule

// File: tb/sd_dma_engine_test.sv
module sd_dma_engine_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] reg_addr = '0;
    logic        reg_we = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        mem_req, mem_we, mem_ack = 1'b0;
    logic [63:0] mem_addr, mem_wdata, mem_rdata = '0;
    logic [1:0]  mem_size;
    logic [63:0] card_wdata, card_rdata = '0;
    logic        card_wvalid, card_wready = 1'b0, card_rvalid = 1'b0, card_rpop;
    logic        irq;

    int checks = 0;
    int errors = 0;
    bit ien = 0;

    always #2.5 clk = ~clk;

    sd_dma_engine uut (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_we(reg_we),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_size(mem_size),
        .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
        .card_wdata(card_wdata), .card_wvalid(card_wvalid), .card_wready(card_wready),
        .card_rdata(card_rdata), .card_rvalid(card_rvalid), .card_rpop(card_rpop),
        .irq(irq)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] v);
        reg_addr = a; reg_wdata = v; reg_we = 1'b1;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] v);
        reg_addr = a;
        #1 v = reg_rdata;
    endtask

    task automatic idle_n(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    function automatic logic [63:0] exp_addr(input logic [63:0] base, input int w, input bit inc, input int k);
        logic [63:0] al;
        al = base & ~((64'd1 << w) - 64'd1);
        return inc ? al + 64'(k) * (64'd1 << w) : al;
    endfunction

    task automatic wait_req(input string req);
        int n = 0;
        while (!mem_req && n < 60) begin @(negedge clk); n++; end
        if (n == 60) chk(req, 64'd0, 64'd1);
    endtask

    task automatic run_xfer(input bit to_mem, input int w, input bit inc,
                            input logic [63:0] base, input int len, input bit dup);
        int b = 1 << w;
        int beats = (len + b - 1) / b;
        logic [31:0] v;
        logic [63:0] pat;
        wr(12'h410, {14'd0, 1'b0, to_mem, 10'd0, 2'(w), 3'd0, inc});
        wr(12'h440, base[31:0]);
        wr(12'h444, base[63:32]);
        wr(12'h41C, 32'(len));
        wr(12'h414, 32'd1);
        if (dup) begin
            // R9: reprogram everything and start again while running
            wr(12'h410, {14'd0, 1'b0, ~to_mem, 10'd0, 2'd0, 3'd0, ~inc});
            wr(12'h440, 32'h5550);
            wr(12'h41C, 32'd64);
            wr(12'h414, 32'd1);
        end
        for (int k = 0; k < beats; k++) begin
            pat = {$urandom, $urandom};
            if (!to_mem) begin
                wait_req("R2");
                chk("R2 read request", {63'd0, mem_we}, 64'd0);
                chk("R4/R5 address", mem_addr, exp_addr(base, w, inc, k));
                chk("R3 size", {62'd0, mem_size}, 64'(w));
                idle_n($urandom % 3);
                chk("R6 request held", {63'd0, mem_req}, 64'd1);
                mem_ack = 1'b1; mem_rdata = pat;
                @(negedge clk);
                mem_ack = 1'b0;
                chk("R2 card word", card_wdata, pat);
                chk("R2 card valid", {63'd0, card_wvalid}, 64'd1);
                idle_n($urandom % 3);
                card_wready = 1'b1;
                @(negedge clk);
                card_wready = 1'b0;
            end else begin
                idle_n($urandom % 3);
                card_rdata = pat; card_rvalid = 1'b1;
                begin
                    int n = 0;
                    #1;
                    while (!card_rpop && n < 60) begin @(negedge clk); #1; n++; end
                    chk("R13 pop", {63'd0, card_rpop}, 64'd1);
                end
                @(negedge clk);
                card_rvalid = 1'b0;
                wait_req("R2");
                chk("R2 write request", {63'd0, mem_we}, 64'd1);
                chk("R2 write data", mem_wdata, pat);
                chk("R4/R5 address", mem_addr, exp_addr(base, w, inc, k));
                chk("R3 size", {62'd0, mem_size}, 64'(w));
                mem_ack = 1'b1;
                @(negedge clk);
                mem_ack = 1'b0;
            end
        end
        idle_n(2);
        rd(12'h420, v);
        chk("R7 data-end set", {32'd0, v}, 64'd1);
        chk("R8 irq", {63'd0, irq}, {63'd0, ien});
        chk("R3 no extra beat", {63'd0, mem_req | card_wvalid}, 64'd0);
        wr(12'h420, 32'd0);
        rd(12'h420, v);
        chk("R7 write 0 keeps", {32'd0, v}, 64'd1);
        wr(12'h420, 32'd1);
        rd(12'h420, v);
        chk("R7 write 1 clears", {32'd0, v}, 64'd0);
        chk("R8 irq low", {63'd0, irq}, 64'd0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] v;
        void'($urandom(32'h5D0A));
        idle_n(3);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        rd(12'h410, v); chk("R1 mode reset", {32'd0, v}, 64'd0);
        rd(12'h418, v); chk("R1 channel reset word", {32'd0, v}, 64'h300);
        rd(12'h420, v); chk("R1 status reset", {32'd0, v}, 64'd0);
        chk("R1 outputs idle", {61'd0, mem_req, card_wvalid, irq}, 64'd0);
        wr(12'h410, 32'hFFFF_FFFF);
        rd(12'h410, v); chk("R1 mode fields", {32'd0, v}, 64'h0003_0031);
        // R10 + R1: both channels held, start is ignored and control reads 0
        wr(12'h418, 32'h0);
        wr(12'h410, 32'h0);
        wr(12'h41C, 32'd8);
        wr(12'h414, 32'd1);
        rd(12'h414, v); chk("R1 start self-clears", {32'd0, v}, 64'd0);
        idle_n(4);
        chk("R10 held ch0 no request", {63'd0, mem_req}, 64'd0);
        // R10: channel 1 held, card-to-memory start ignored
        wr(12'h418, 32'h100);
        wr(12'h410, 32'h0001_0000);
        wr(12'h414, 32'd1);
        card_rvalid = 1'b1;
        #1 chk("R10 held ch1 no pop", {63'd0, card_rpop}, 64'd0);
        idle_n(4);
        chk("R10 held ch1 no pop later", {62'd0, card_rpop, mem_req}, 64'd0);
        card_rvalid = 1'b0;
        rd(12'h420, v); chk("R10 no data-end", {32'd0, v}, 64'd0);
        run_xfer(0, 3, 1, 64'h1000, 16, 0);   // ch0 still usable
        wr(12'h418, 32'h300);
        // directed patterns
        run_xfer(0, 3, 1, 64'h0000_0000_0000_2000, 32, 0);
        run_xfer(1, 0, 0, 64'h0000_0000_0000_0777, 5, 0);
        run_xfer(1, 3, 1, 64'h0000_0012_FFFF_FFF8, 24, 0);  // R5 carry
        run_xfer(0, 2, 1, 64'h0000_0000_0000_1003, 8, 0);   // R5 alignment
        run_xfer(1, 1, 1, 64'h0000_0000_0000_4000, 5, 0);   // R3 partial beat
        // R8 interrupt enable
        ien = 1; wr(12'h424, 32'd1);
        run_xfer(0, 1, 0, 64'h8000_0000_0000_0010, 6, 0);
        ien = 0; wr(12'h424, 32'd0);
        // R9 start while busy
        run_xfer(1, 3, 1, 64'h2000, 16, 1);
        run_xfer(0, 2, 0, 64'h3000, 12, 1);
        // R12 zero length
        wr(12'h410, 32'h0); wr(12'h41C, 32'd0); wr(12'h414, 32'd1);
        idle_n(3);
        chk("R12 no request", {63'd0, mem_req}, 64'd0);
        rd(12'h420, v); chk("R12 data-end", {32'd0, v}, 64'd1);
        wr(12'h420, 32'd1);
        // R11 abort mid transfer
        wr(12'h410, 32'h30); wr(12'h440, 32'h6000); wr(12'h444, 32'h0);
        wr(12'h41C, 32'd64); wr(12'h414, 32'd1);
        wait_req("R11");
        wr(12'h418, 32'h0);
        @(negedge clk);
        chk("R11 request dropped", {63'd0, mem_req}, 64'd0);
        idle_n(4);
        chk("R11 stays idle", {62'd0, mem_req, card_wvalid}, 64'd0);
        rd(12'h420, v); chk("R11 no data-end", {32'd0, v}, 64'd0);
        wr(12'h418, 32'h300);
        run_xfer(0, 3, 1, 64'h6000, 16, 0);
        // random transfers
        for (int t = 0; t < 30; t++) begin
            run_xfer($urandom % 2, $urandom % 4, $urandom % 2,
                     {$urandom, $urandom}, $urandom % 40, 0);
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule